// File: doc/BRIEF.md
# T1 Transmit Frame Sync Controller

This block marks the frame and multiframe boundaries for a T1 transmitter. A 193-bit frame counter and a 24-frame multiframe counter run on the transmit serial clock. Two sync pads can either be driven by the block, which then pulses them at each boundary, or be sampled from equipment on the system side, which then sets where frames and multiframes begin.

The pad direction comes from a small configuration register. That register holds a direction-select bit and a 2-bit timing-source code. The select bit has one meaning when the transmit serial clock is the timing source. It has the opposite meaning when the recovered line clock or the internal clock is the timing source. Output enables for both pads are provided so that bidirectional pad cells can be connected directly.

Reset is asynchronous and active-low. Its release is synchronised inside the block. Strobes for frame start and multiframe start, together with the live counter values, go to the rest of the transmit path.

Top module: `tx_fsync_ctrl`

## Requirements
- R1: Configuration word layout is bit 2 = direction select, bits 1:0 = timing source. With source code 01 (transmit serial clock), select 0 makes both sync pads inputs (`fsync_oe`=`msync_oe`=0) and select 1 makes them outputs (enables 1).
- R2: With source codes 00 or 11 (recovered clock) or 10 (internal clock), select 0 makes both pads outputs and select 1 makes them inputs.
- R3: A write with `cfg_we`=1 stores `cfg_wdata` at the clock edge. `cfg_rdata` returns the stored word. The stored word is 0 in reset.
- R4: Both output enables are 1 for as long as `rst_n` is low. After a write, the enables follow the new configuration in the same cycle that `cfg_rdata` shows it.
- R5: With no accepted sync input, `bit_idx` counts 0..192 and wraps to 0. `frame_idx` advances when `bit_idx` wraps and runs 0..23 before returning to 0.
- R6: In output mode, `fsync_out` is high exactly when `bit_idx`=0. `msync_out` is high exactly when `bit_idx`=0 and `frame_idx`=0. `frame_start` and `mframe_start` follow the same two conditions in either mode.
- R7: In input mode, `fsync_in` sampled high at a clock edge sets `bit_idx` to 0 after that edge and advances `frame_idx` by one, wrapping 23 to 0.
- R8: In input mode, `msync_in` sampled high sets both counters to 0 after that edge. It takes priority over `fsync_in`.
- R9: In output mode, `fsync_in` and `msync_in` have no effect on the counters.
- R10: In input mode, `fsync_out` and `msync_out` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Configuration write data {select, source[1:0]} |
| cfg_rdata | output | 3 | Stored configuration word |
| fsync_in | input | 1 | Frame sync sampled from the pad |
| msync_in | input | 1 | Multiframe sync sampled from the pad |
| fsync_out | output | 1 | Frame sync driven to the pad |
| msync_out | output | 1 | Multiframe sync driven to the pad |
| fsync_oe | output | 1 | Frame sync pad output enable |
| msync_oe | output | 1 | Multiframe sync pad output enable |
| frame_start | output | 1 | High in bit 0 of every frame |
| mframe_start | output | 1 | High in bit 0 of frame 0 |
| bit_idx | output | 8 | Bit position in frame, 0..192 |
| frame_idx | output | 5 | Frame position in multiframe, 0..23 |

## Verification
The bench walks through all eight configuration words. A design that failed to invert the select bit for non-serial sources, or that decoded code 11 as anything other than the recovered clock, would turn the pads the wrong way. In output mode the bench toggles the sync inputs and runs a full multiframe. A design that still listened to its pads there would lose its count. In input mode the bench sends frame syncs at many bit positions, multiframe syncs both alone and together with frame syncs, and long gaps that cross the 192 and 23 wraps. A design with an off-by-one terminal count or the wrong sync priority would drift from the expected counters within a few cycles.

// File: rtl/tfs_pkg.sv
`timescale 1ns/1ps
package tfs_pkg;
  typedef enum logic [1:0] {
    SRC_RECOV_A = 2'b00,
    SRC_SERIAL  = 2'b01,
    SRC_INTERN  = 2'b10,
    SRC_RECOV_B = 2'b11
  } clk_src_e;

  typedef struct packed {
    logic     dir_sel;
    clk_src_e src;
  } sync_cfg_t;

  localparam int CFG_W = $bits(sync_cfg_t);
endpackage

// File: rtl/tfs_cfg_reg.sv
`timescale 1ns/1ps
module tfs_cfg_reg
  import tfs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output sync_cfg_t        cfg_q
);
  sync_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = sync_cfg_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q)); // R3
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q == $past(wr_data))); // R3
endmodule

// File: rtl/tfs_dir_decode.sv
`timescale 1ns/1ps
module tfs_dir_decode
  import tfs_pkg::*;
(
  input  sync_cfg_t cfg,
  output logic      drive_pads
);
  logic src_is_serial;

  always_comb begin
    src_is_serial = (cfg.src == SRC_SERIAL);
    // Select bit polarity flips with the timing source.
    if (src_is_serial) drive_pads = cfg.dir_sel;
    else               drive_pads = ~cfg.dir_sel;
  end

  always_comb begin
    AST_DIR_SERIAL: assert (!(cfg.src == SRC_SERIAL) || (drive_pads == cfg.dir_sel)); // R1
    AST_DIR_OTHER:  assert ((cfg.src == SRC_SERIAL) || (drive_pads != cfg.dir_sel)); // R2
  end
endmodule

// File: rtl/tfs_counter.sv
`timescale 1ns/1ps
module tfs_counter #(
  parameter int FRAME_BITS = 193,
  parameter int MF_FRAMES  = 24,
  localparam int BW = $clog2(FRAME_BITS),
  localparam int FW = $clog2(MF_FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_mode,
  input  logic          fs_in,
  input  logic          ms_in,
  output logic [BW-1:0] bit_q,
  output logic [FW-1:0] frame_q
);
  localparam logic [BW-1:0] BIT_LAST   = BW'(FRAME_BITS - 1);
  localparam logic [FW-1:0] FRAME_LAST = FW'(MF_FRAMES - 1);

  logic          ms_take, fs_take, bit_wrap, frame_step;
  logic [BW-1:0] bit_d;
  logic [FW-1:0] frame_d, frame_inc;

  always_comb begin
    ms_take    = ext_mode & ms_in;
    fs_take    = ext_mode & fs_in & ~ms_in;
    bit_wrap   = (bit_q == BIT_LAST);
    frame_inc  = (frame_q == FRAME_LAST) ? '0 : frame_q + 1'b1;
    frame_step = fs_take | bit_wrap;
    bit_d      = bit_q + 1'b1;
    frame_d    = frame_q;
    if (ms_take) begin
      bit_d   = '0;
      frame_d = '0;
    end else if (frame_step) begin
      bit_d   = '0;
      frame_d = frame_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= '0;
      frame_q <= '0;
    end else begin
      bit_q   <= bit_d;
      frame_q <= frame_d;
    end
  end

  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= BIT_LAST); // R5
  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q <= FRAME_LAST); // R5
  AST_BIT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_q == BIT_LAST) |=> (bit_q == '0)); // R5
  AST_FS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && fs_in) |=> (bit_q == '0)); // R7
  AST_MS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && ms_in) |=> (bit_q == '0 && frame_q == '0)); // R8
  AST_PADS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && bit_q != BIT_LAST) |=> (bit_q == $past(bit_q) + 1'b1)); // R9
endmodule

// File: rtl/tx_fsync_ctrl.sv
`timescale 1ns/1ps
module tx_fsync_ctrl
  import tfs_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  parameter int MF_FRAMES  = 24,
  localparam int BW = $clog2(FRAME_BITS),
  localparam int FW = $clog2(MF_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             fsync_in,
  input  logic             msync_in,
  output logic             fsync_out,
  output logic             msync_out,
  output logic             fsync_oe,
  output logic             msync_oe,
  output logic             frame_start,
  output logic             mframe_start,
  output logic [BW-1:0]    bit_idx,
  output logic [FW-1:0]    frame_idx
);
  logic      rst_meta, rst_sync_n;
  sync_cfg_t cfg_q;
  logic      drive_pads;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  tfs_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .cfg_q   (cfg_q)
  );

  tfs_dir_decode u_dir (
    .cfg        (cfg_q),
    .drive_pads (drive_pads)
  );

  tfs_counter #(.FRAME_BITS(FRAME_BITS), .MF_FRAMES(MF_FRAMES)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ext_mode (~drive_pads),
    .fs_in    (fsync_in),
    .ms_in    (msync_in),
    .bit_q    (bit_idx),
    .frame_q  (frame_idx)
  );

  always_comb begin
    cfg_rdata    = cfg_q;
    fsync_oe     = drive_pads;
    msync_oe     = drive_pads;
    frame_start  = (bit_idx == '0);
    mframe_start = frame_start & (frame_idx == '0);
    fsync_out    = drive_pads & frame_start;
    msync_out    = drive_pads & mframe_start;
  end

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fsync_oe |-> (!fsync_out && !msync_out)); // R10
  AST_MS_IMPLIES_FS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mframe_start |-> frame_start); // R6
  AST_OE_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> (fsync_oe && msync_oe)); // R4
endmodule

// File: tb/tx_fsync_ctrl_tb_top.sv
`timescale 1ns/1ps
module tx_fsync_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic [2:0] cfg_rdata;
  logic       fsync_in = 1'b0, msync_in = 1'b0;
  logic       fsync_out, msync_out, fsync_oe, msync_oe;
  logic       frame_start, mframe_start;
  logic [7:0] bit_idx;
  logic [4:0] frame_idx;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model state
  bit       mdl_on = 1'b0;
  int       mb = 0, mf = 0;
  bit [2:0] mcfg = '0;

  always #4 clk = ~clk;

  tx_fsync_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .fsync_in(fsync_in), .msync_in(msync_in),
    .fsync_out(fsync_out), .msync_out(msync_out), .fsync_oe(fsync_oe),
    .msync_oe(msync_oe), .frame_start(frame_start), .mframe_start(mframe_start),
    .bit_idx(bit_idx), .frame_idx(frame_idx)
  );

  // R1/R2 arithmetic: drive pads when select equals (source == 01)
  function automatic bit drives(bit [2:0] c);
    return (c[1:0] == 2'b01) ? c[2] : !c[2];
  endfunction

  always @(posedge clk) begin
    if (mdl_on) begin
      bit ext;
      ext = !drives(mcfg);
      if (cfg_we) mcfg = cfg_wdata;
      if (ext && msync_in) begin mb = 0; mf = 0; end            // R8
      else if (ext && fsync_in) begin mb = 0; mf = (mf + 1) % 24; end // R7
      else if (mb == 192) begin mb = 0; mf = (mf + 1) % 24; end  // R5
      else mb = mb + 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_cycle();
    bit o;
    int exp_v, act_v;
    string tag;
    o = drives(mcfg);
    exp_v = {o, o, o && mb == 0, o && mb == 0 && mf == 0,
             mb == 0, mb == 0 && mf == 0, mb[7:0], mf[4:0]};
    act_v = {fsync_oe, msync_oe, fsync_out, msync_out,
             frame_start, mframe_start, bit_idx, frame_idx};
    if (o) tag = "R6 R9 R5";
    else   tag = "R7 R8 R10 R5";
    chk(tag, act_v, exp_v);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk_cycle();
    end
  endtask

  task automatic write_cfg(bit [2:0] v);
    cfg_we = 1'b1;
    cfg_wdata = v;
    step(1);
    cfg_we = 1'b0;
    chk("R3 readback", cfg_rdata, v);
    chk("R4 enable follows write", fsync_oe, drives(v));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // Reset state: R3, R4
    repeat (3) @(negedge clk);
    chk("R4 fsync_oe in reset", fsync_oe, 1);
    chk("R4 msync_oe in reset", msync_oe, 1);
    chk("R3 reset value", cfg_rdata, 0);
    chk("R5 bit in reset", bit_idx, 0);
    rst_n = 1'b1;
    chk("R4 oe at release", fsync_oe, 1);
    while (bit_idx != 8'd1) @(negedge clk);
    mb = 1; mf = 0; mcfg = '0; mdl_on = 1'b1;

    // R1, R2: all eight configuration words
    for (int v = 0; v < 8; v++) begin
      write_cfg(3'(v));
      step(2);
    end
    for (int v = 7; v >= 0; v--) write_cfg(3'(v));

    // Output mode, inputs toggling and ignored: R9, R6
    write_cfg(3'b000);
    for (int i = 0; i < 4700; i++) begin
      fsync_in = (i % 7) == 3;
      msync_in = (i % 11) == 5;
      step(1);
    end
    fsync_in = 0; msync_in = 0;

    // Input mode with serial source: R7, R8, R10
    write_cfg(3'b001);
    for (int i = 0; i < 6000; i++) begin
      fsync_in = ((i % 157) == 5) || ((i % 1031) == 400);
      msync_in = ((i % 997) == 3) || ((i % 1031) == 400);
      step(1);
    end
    fsync_in = 0; msync_in = 0;

    // Input mode with recovered source, free-run across wraps: R2, R5
    write_cfg(3'b100);
    step(4700);
    for (int i = 0; i < 800; i++) begin
      fsync_in = (i % 193) == 192 || (i % 61) == 0;
      msync_in = (i == 500);
      step(1);
    end
    fsync_in = 0; msync_in = 0;

    // Internal source input mode then back to output: R2, R1
    write_cfg(3'b110);
    fsync_in = 1; step(1); fsync_in = 0; step(5);
    write_cfg(3'b101);
    fsync_in = 1; msync_in = 1; step(200);
    fsync_in = 0; msync_in = 0;
    write_cfg(3'b011);
    step(10);
    summary();
  end
endmodule